// File: doc/BRIEF.md
# Calibrated Read-Valid Latency Generator

This block sits between a memory controller and the read path of a half-rate memory PHY. Each time the controller issues a read, it raises a two-bit read strobe. Each bit stands for one half of the slow controller clock cycle. The block delays every strobe bit by a calibrated number of controller-clock cycles and presents the result as a two-bit read-data-valid flag. Bit 0 marks returned data in the first half of a controller cycle and bit 1 marks returned data in the second half. Each half has its own delay line, so a read that starts in either half keeps its own alignment.

The delay comes from a latency value that calibration supplies. The block captures that value once, on the rising edge of the calibration-done flag, and reports it back to the controller. Until that capture, the valid flag stays low and the reported latency reads zero. After the capture, the stored latency is frozen until reset, whatever the calibration inputs do.

Top module: `rd_valid_gen`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `rd_valid` is 0 and `lat_out` is 0. A reset also discards any previously captured latency.
- R2: Before a latency has been captured, `rd_valid` is 0 and `lat_out` is 0, whatever `rd_req` does.
- R3: When `cal_done` is sampled high at a clock edge after having been sampled low (or reset), the value of `cal_lat` at that edge is stored. `lat_out` shows the stored value from the next cycle onward.
- R4: Once a value is stored, later changes on `cal_lat`, and `cal_done` falling and rising again, change neither `lat_out` nor the delay applied to reads, until reset.
- R5: With stored latency L (0 to 31), a strobe on `rd_req[s]` in cycle t produces `rd_valid[s]` high in cycle t+L. When L is 0, the valid bit appears in the same cycle as the strobe.
- R6: Bit 0 (first half-cycle) and bit 1 (second half-cycle) are delayed independently. A strobe on one bit never shows on the other bit.
- R7: Strobes in consecutive cycles give valid pulses in consecutive cycles. Each strobe bit produces exactly one valid beat, with none dropped or merged.
- R8: A strobe that arrives before the capture cycle, or during it, never produces a valid beat, even after the capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | SLOTS (2) | Read-in-progress strobe, one bit per half-cycle slot |
| cal_done | input | 1 | Calibration finished successfully |
| cal_lat | input | LAT_W (5) | Latency found by calibration, in controller cycles |
| rd_valid | output | SLOTS (2) | Read data valid, one bit per half-cycle slot |
| lat_out | output | LAT_W (5) | Stored latency reported to the controller, zero until captured |

## Verification
The bench builds the block with its default parameters: a 5-bit latency and two slots. These values bring the whole delay range within reach, including the zero-latency bypass and the 31-stage tap at the far end of each line. Resetting between scenarios lets the run re-calibrate several times with latencies of 0, 1, 3, 4, 5, 7 and 31. This exercises capture and freezing at each of those values, as well as strobes that arrive before the latency is locked.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

    localparam int unsigned LAT_W_DEF = 5;
    localparam int unsigned SLOTS_DEF = 2;

    typedef enum logic {
        PH_CAL = 1'b0,
        PH_RUN = 1'b1
    } phase_e;

    function automatic logic rose_now(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/rdv_lat_lock.sv
module rdv_lat_lock
    import rdv_pkg::*;
#(
    parameter int unsigned LAT_W = LAT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cal_done,
    input  logic [LAT_W-1:0] cal_lat,
    output logic             locked,
    output logic [LAT_W-1:0] lat_q
);

    typedef struct packed {
        phase_e           ph;
        logic             done_q;
        logic [LAT_W-1:0] lat;
    } lock_st_t;

    lock_st_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{ph: PH_CAL, done_q: 1'b0, lat: '0};
        end else begin
            st.done_q <= cal_done;
            if (st.ph == PH_CAL && rose_now(cal_done, st.done_q)) begin
                st.ph  <= PH_RUN;
                st.lat <= cal_lat;
            end
        end
    end

    assign locked = (st.ph == PH_RUN);
    assign lat_q  = st.lat;

    assert_locked_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    assert_lat_hold_R4: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(lat_q));

endmodule

// File: rtl/rdv_delay_tap.sv
module rdv_delay_tap
    import rdv_pkg::*;
#(
    parameter int unsigned LAT_W = LAT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             din,
    input  logic [LAT_W-1:0] sel,
    output logic             dout
);

    localparam int unsigned DEPTH = (1 << LAT_W) - 1;

    logic [DEPTH-1:0] sr;
    logic             tap;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= din & en;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[DEPTH-2:0], din & en};
            end
        end
    endgenerate

    always_comb begin
        if (sel == '0) tap = din;
        else           tap = sr[sel - 1'b1];
    end

    assign dout = en & tap;

    assert_one_stage_R5: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && sel == LAT_W'(1)) |-> (dout == $past(din)));

    assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
        (en && sel == '0) |-> (dout == din));

endmodule

// File: rtl/rd_valid_gen.sv
module rd_valid_gen
    import rdv_pkg::*;
#(
    parameter int unsigned LAT_W = LAT_W_DEF,
    parameter int unsigned SLOTS = SLOTS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] rd_req,
    input  logic             cal_done,
    input  logic [LAT_W-1:0] cal_lat,
    output logic [SLOTS-1:0] rd_valid,
    output logic [LAT_W-1:0] lat_out
);

    logic             locked;
    logic [LAT_W-1:0] lat_q;

    rdv_lat_lock #(.LAT_W(LAT_W)) lock_i (
        .clk      (clk),
        .rst      (rst),
        .cal_done (cal_done),
        .cal_lat  (cal_lat),
        .locked   (locked),
        .lat_q    (lat_q)
    );

    genvar s;
    generate
        for (s = 0; s < SLOTS; s++) begin : g_slot
            rdv_delay_tap #(.LAT_W(LAT_W)) tap_i (
                .clk  (clk),
                .rst  (rst),
                .en   (locked),
                .din  (rd_req[s]),
                .sel  (lat_q),
                .dout (rd_valid[s])
            );
        end
    endgenerate

    assign lat_out = locked ? lat_q : '0;

    assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !locked |-> (rd_valid == '0 && lat_out == '0));

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (!locked && $rose(cal_done)) |=> (lat_out == $past(cal_lat)));

    assert_report_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(lat_out));

endmodule

// File: tb/rd_valid_gen_tb_top.sv
module rd_valid_gen_tb_top;

    localparam int unsigned LAT_W = 5;
    localparam int unsigned SLOTS = 2;

    logic             clk = 1'b0;
    logic             rst;
    logic [SLOTS-1:0] rd_req;
    logic             cal_done;
    logic [LAT_W-1:0] cal_lat;
    logic [SLOTS-1:0] rd_valid;
    logic [LAT_W-1:0] lat_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [1:0] pat [0:15];

    always #4 clk = ~clk;

    rd_valid_gen #(.LAT_W(LAT_W), .SLOTS(SLOTS)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .cal_done (cal_done),
        .cal_lat  (cal_lat),
        .rd_valid (rd_valid),
        .lat_out  (lat_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_req = '0; cal_done = 1'b0; cal_lat = '0;
        repeat (3) @(negedge clk);
        #1;
        check(rd_valid == '0, "R1 valid in reset", rd_valid, 0);
        check(lat_out == '0, "R1 latency in reset", lat_out, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(lat_out == '0, "R1 latency after reset", lat_out, 0);
    endtask

    task automatic lock(input int lat);
        @(negedge clk);
        cal_lat = LAT_W'(lat); cal_done = 1'b1;
        @(negedge clk);
        #1;
        check(lat_out == LAT_W'(lat), "R3 captured latency", lat_out, lat);
    endtask

    task automatic set_pat(input logic [31:0] v);
        for (int i = 0; i < 16; i++) pat[i] = v[2*i +: 2];
    endtask

    task automatic run_pattern(input int lat, input int n, input string req);
        int beats_exp = 0;
        int beats_act = 0;
        for (int t = 0; t < n + lat + 3; t++) begin
            logic [1:0] exp;
            @(negedge clk);
            rd_req = (t < n) ? pat[t] : 2'b00;
            #1;
            exp = (t >= lat && t - lat < n) ? pat[t - lat] : 2'b00;
            beats_exp += int'(exp[0]) + int'(exp[1]);
            beats_act += int'(rd_valid[0]) + int'(rd_valid[1]);
            check(rd_valid == exp, req, rd_valid, exp);
        end
        check(beats_act == beats_exp, "R7 beat count", beats_act, beats_exp);
    endtask

    task automatic t_before_cal();
        do_reset();
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            rd_req = 2'(t % 4);
            #1;
            check(rd_valid == '0, "R2 valid before lock", rd_valid, 0);
            check(lat_out == '0, "R2 latency before lock", lat_out, 0);
        end
        @(negedge clk);
        rd_req = 2'b11; cal_lat = 5'd5; cal_done = 1'b1;
        #1;
        check(rd_valid == '0, "R8 valid in capture cycle", rd_valid, 0);
        @(negedge clk);
        rd_req = '0;
        #1;
        check(lat_out == 5'd5, "R3 captured latency", lat_out, 5);
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            #1;
            check(rd_valid == '0, "R8 early strobe leaked", rd_valid, 0);
        end
    endtask

    task automatic t_basic();
        do_reset();
        lock(3);
        set_pat(32'h0000_90E1);
        run_pattern(3, 8, "R5 R6 mixed slots L=3");
    endtask

    task automatic t_back_to_back();
        do_reset();
        lock(1);
        set_pat(32'h0003_297F);
        run_pattern(1, 9, "R7 back-to-back L=1");
    endtask

    task automatic t_zero();
        do_reset();
        lock(0);
        set_pat(32'h0000_0339);
        run_pattern(0, 5, "R5 bypass L=0");
    endtask

    task automatic t_max();
        do_reset();
        lock(31);
        set_pat(32'h0000_0081);
        run_pattern(31, 4, "R5 R6 max L=31");
    endtask

    task automatic t_frozen();
        do_reset();
        lock(4);
        @(negedge clk);
        cal_lat = 5'd9; cal_done = 1'b0;
        #1;
        check(lat_out == 5'd4, "R4 latency after input change", lat_out, 4);
        @(negedge clk);
        cal_done = 1'b1;
        #1;
        check(lat_out == 5'd4, "R4 latency with done low", lat_out, 4);
        @(negedge clk);
        #1;
        check(lat_out == 5'd4, "R4 latency after re-rise", lat_out, 4);
        set_pat(32'h0000_90E1);
        run_pattern(4, 8, "R4 delay unchanged L=4");
    endtask

    task automatic t_relock();
        do_reset();
        check(lat_out == '0, "R1 reset clears latency", lat_out, 0);
        lock(7);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; rd_req = '0; cal_done = 1'b0; cal_lat = '0;
        t_before_cal();
        t_basic();
        t_back_to_back();
        t_zero();
        t_max();
        t_frozen();
        t_relock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule